// File: doc/BRIEF.md
# Tone Duration Guard Validator

This block is the digital steering stage that follows a dual-tone frequency detector. The detector supplies a level that is high while a valid tone pair is being heard (the early-steering input) and the 4-bit code of that pair. The validator decides when a tone has really started and when it has really ended. Up/down guard counting replaces the resistor-capacitor timing network of an analogue receiver.

A tone is accepted only after the early-steering input has stayed high for a programmable number of clock cycles. Its code is then loaded into the receive register. Two cycles later the delayed-steering level rises, together with a single-cycle new-data strobe. Once a tone is held, the input must stay low for a separate programmable count before the pause is accepted and the delayed-steering level falls. Short bursts are therefore rejected and short dropouts inside a tone are bridged. The two guard counts are run-time inputs, so either one may be the longer.

Top module: `tone_guard_validator`

## Requirements
- R1: After reset the receive code is 0, the delayed-steering level is low and the new-data strobe is low.
- R2: A tone is registered only when the early-steering input is sampled high on `present_guard_i` consecutive clock edges (a value of 0 acts as 1). A shorter burst leaves the receive code, delayed steering and strobe unchanged.
- R3: The receive code takes the value of `code_i` sampled on the edge that completes the present guard, and shows it from the next cycle on.
- R4: The delayed-steering level rises exactly two cycles after the receive code is updated. The new-data strobe is high for exactly one cycle: the first cycle in which delayed steering is high.
- R5: While a tone is held, a low period of fewer than `absent_guard_i` consecutive edges is bridged. Delayed steering stays high, the receive code is unchanged, and no strobe is issued when the tone returns.
- R6: The end of a tone is accepted after `absent_guard_i` consecutive low samples, and delayed steering falls two cycles after that edge. The receive code is kept until the next registration.
- R7: The present and absent guard counts act independently, so the present count may be shorter or longer than the absent count.
- R8: Any low sample during the present guard restarts the count, so separate bursts do not add up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| est_i | input | 1 | Early steering: valid tone pair currently detected |
| code_i | input | CODE_W | Code of the detected tone pair |
| present_guard_i | input | CNT_W | Consecutive high samples needed to accept a tone |
| absent_guard_i | input | CNT_W | Consecutive low samples needed to accept a pause |
| rx_code_o | output | CODE_W | Latched receive code |
| steer_o | output | 1 | Delayed-steering level |
| new_data_o | output | 1 | One-cycle strobe per registered tone |

## Verification
The bench builds the block with CNT_W = 8, CODE_W = 4 and the fixed two-cycle settle delay. It drives guard counts of a few cycles, first 5 present / 3 absent and then 2 present / 6 absent. With these short windows the exact boundary is reachable in a few dozen cycles: a burst one sample short is rejected, a dropout one sample short is bridged, and either guard can be the longer one. Each registration is checked cycle by cycle for code first, flag two cycles later, and a single strobe.

// File: rtl/tgv_pkg.sv
package tgv_pkg;

    typedef enum logic {
        GS_ABSENT  = 1'b0,
        GS_PRESENT = 1'b1
    } guard_state_e;

endpackage

// File: rtl/tgv_guard_fsm.sv
module tgv_guard_fsm
    import tgv_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             est_i,
    input  logic [CNT_W-1:0] present_guard_i,
    input  logic [CNT_W-1:0] absent_guard_i,
    output guard_state_e     state_o,
    output logic             accept_o
);

    localparam int unsigned EXT_W = CNT_W + 1;

    typedef struct packed {
        guard_state_e     state;
        logic [CNT_W-1:0] cnt;
    } guard_s;

    guard_s           cur_q, nxt_d;
    logic [EXT_W-1:0] cnt_inc;
    logic             accept_d;

    always_comb begin
        nxt_d    = cur_q;
        accept_d = 1'b0;
        cnt_inc  = {1'b0, cur_q.cnt} + EXT_W'(1);
        case (cur_q.state)
            GS_ABSENT: begin
                if (est_i) begin
                    if (cnt_inc >= {1'b0, present_guard_i}) begin
                        nxt_d.state = GS_PRESENT;
                        nxt_d.cnt   = '0;
                        accept_d    = 1'b1;
                    end else begin
                        nxt_d.cnt = cnt_inc[CNT_W-1:0];
                    end
                end else begin
                    nxt_d.cnt = '0;
                end
            end
            default: begin
                if (!est_i) begin
                    if (cnt_inc >= {1'b0, absent_guard_i}) begin
                        nxt_d.state = GS_ABSENT;
                        nxt_d.cnt   = '0;
                    end else begin
                        nxt_d.cnt = cnt_inc[CNT_W-1:0];
                    end
                end else begin
                    nxt_d.cnt = '0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: GS_ABSENT, cnt: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign state_o  = cur_q.state;
    assign accept_o = accept_d;

    logic is_present;
    assign is_present = (cur_q.state == GS_PRESENT);

    assert_enter_needs_tone_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(is_present) |-> $past(est_i));

    assert_leave_needs_silence_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(is_present) |-> !$past(est_i));

endmodule

// File: rtl/tgv_settle.sv
module tgv_settle #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic level_o,
    output logic rise_o
);

    typedef struct packed {
        logic [DEPTH-1:0] chain;
        logic             last;
    } settle_s;

    settle_s          cur_q, nxt_d;
    logic [DEPTH-1:0] shifted;

    generate
        if (DEPTH == 1) begin : g_single
            assign shifted = level_i;
        end else begin : g_multi
            assign shifted = {cur_q.chain[DEPTH-2:0], level_i};
        end
    endgenerate

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.chain = shifted;
        nxt_d.last  = cur_q.chain[DEPTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign level_o = cur_q.chain[DEPTH-1];
    assign rise_o  = cur_q.chain[DEPTH-1] & ~cur_q.last;

endmodule

// File: rtl/tone_guard_validator.sv
module tone_guard_validator
    import tgv_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned CODE_W = 4,
    parameter int unsigned SETTLE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              est_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic [CNT_W-1:0]  present_guard_i,
    input  logic [CNT_W-1:0]  absent_guard_i,
    output logic [CODE_W-1:0] rx_code_o,
    output logic              steer_o,
    output logic              new_data_o
);

    typedef struct packed {
        logic [CODE_W-1:0] rx_code;
    } top_s;

    top_s         cur_q, nxt_d;
    guard_state_e gstate;
    logic         accept;
    logic         held;

    tgv_guard_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .est_i           (est_i),
        .present_guard_i (present_guard_i),
        .absent_guard_i  (absent_guard_i),
        .state_o         (gstate),
        .accept_o        (accept)
    );

    assign held = (gstate == GS_PRESENT);

    tgv_settle #(.DEPTH(SETTLE)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (held),
        .level_o (steer_o),
        .rise_o  (new_data_o)
    );

    always_comb begin
        nxt_d = cur_q;
        if (accept) begin
            nxt_d.rx_code = code_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rx_code_o = cur_q.rx_code;

    assert_code_moves_on_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_code_o) |-> $rose(held));

    assert_strobe_with_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        new_data_o |-> steer_o);

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        new_data_o |=> !new_data_o);

    assert_flag_after_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(steer_o) |-> $past(held));

endmodule

// File: tb/tone_guard_validator_tb.sv
module tone_guard_validator_tb;

    localparam int unsigned CNT_W  = 8;
    localparam int unsigned CODE_W = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              est_i = 1'b0;
    logic [CODE_W-1:0] code_i = '0;
    logic [CNT_W-1:0]  present_guard_i = 8'd5;
    logic [CNT_W-1:0]  absent_guard_i = 8'd3;
    logic [CODE_W-1:0] rx_code_o;
    logic              steer_o;
    logic              new_data_o;

    int total = 0;
    int fails = 0;
    int strobes = 0;

    always #4 clk = ~clk;

    tone_guard_validator #(.CNT_W(CNT_W), .CODE_W(CODE_W), .SETTLE(2)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .est_i           (est_i),
        .code_i          (code_i),
        .present_guard_i (present_guard_i),
        .absent_guard_i  (absent_guard_i),
        .rx_code_o       (rx_code_o),
        .steer_o         (steer_o),
        .new_data_o      (new_data_o)
    );

    always @(posedge clk) begin
        if (rst_n && new_data_o) strobes <= strobes + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        step(3);
        chk("R1 code", rx_code_o, 0);
        chk("R1 steer", steer_o, 0);
        chk("R1 strobe", new_data_o, 0);
        rst_n = 1'b1;
        step(2);
        chk("R1 steer idle", steer_o, 0);
    endtask

    task automatic t_short_burst();
        est_i = 1'b1; code_i = 4'd4; step(4);
        est_i = 1'b0; step(1);
        est_i = 1'b1; step(3);
        est_i = 1'b0; step(1);
        est_i = 1'b1; step(4);
        est_i = 1'b0; step(6);
        chk("R2 code unchanged", rx_code_o, 0);
        chk("R2 steer low", steer_o, 0);
        chk("R8 no strobe", strobes, 0);
    endtask

    task automatic t_register();
        est_i = 1'b1; code_i = 4'd3; step(4);
        code_i = 4'd7; step(1);
        chk("R3 code latched", rx_code_o, 7);
        chk("R4 flag not yet", steer_o, 0);
        step(1);
        chk("R4 flag settle", steer_o, 0);
        chk("R4 strobe early", new_data_o, 0);
        step(1);
        chk("R4 flag up", steer_o, 1);
        chk("R4 strobe up", new_data_o, 1);
        step(1);
        chk("R4 strobe one cycle", new_data_o, 0);
        chk("R4 strobe count", strobes, 1);
    endtask

    task automatic t_dropout();
        est_i = 1'b0; code_i = 4'd9; step(2);
        chk("R5 steer held", steer_o, 1);
        est_i = 1'b1; step(10);
        chk("R5 code kept", rx_code_o, 7);
        chk("R5 steer kept", steer_o, 1);
        chk("R5 no new strobe", strobes, 1);
    endtask

    task automatic t_pause();
        est_i = 1'b0; step(3);
        chk("R6 steer before settle", steer_o, 1);
        step(1);
        chk("R6 steer settle", steer_o, 1);
        step(1);
        chk("R6 steer falls", steer_o, 0);
        step(5);
        chk("R6 code retained", rx_code_o, 7);
    endtask

    task automatic t_swapped_guards();
        present_guard_i = 8'd2; absent_guard_i = 8'd6;
        est_i = 1'b1; code_i = 4'd2; step(1);
        est_i = 1'b0; step(2);
        chk("R7 one sample short", rx_code_o, 7);
        est_i = 1'b1; code_i = 4'd11; step(2);
        chk("R7 short present guard", rx_code_o, 11);
        step(3);
        chk("R7 steer up", steer_o, 1);
        chk("R7 strobe count", strobes, 2);
        est_i = 1'b0; step(5);
        chk("R7 long absent bridges", steer_o, 1);
        est_i = 1'b1; step(3);
        chk("R5 no repeat strobe", strobes, 2);
        est_i = 1'b0; step(6);
        step(2);
        chk("R7 pause accepted", steer_o, 0);
        chk("R6 code retained", rx_code_o, 11);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_reset();
        t_short_burst();
        t_register();
        t_dropout();
        t_pause();
        t_swapped_guards();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule